// File: doc/BRIEF.md
# Thermal Shutdown Monitor

This block watches up to four temperature-sensor channels. Once automatic mode is on, it asks an external converter for one 12-bit code at a time. It visits the enabled channels in rising index order and waits a programmed number of sample-clock ticks between requests. The converter scale is inverted: a smaller code means a hotter die. A channel counts as beyond a threshold when its code is less than or equal to that threshold.

Each channel has two thresholds, each with its own debounce count:
- An interrupt threshold sets a per-channel pending bit.
- A shutdown threshold latches a per-channel shutdown state.

The latched shutdown can drive an external pin with selectable polarity, a request to the clock/reset unit, or both. When any enabled channel is hot, the scan uses a separate, usually shorter, period.

A sticky flag records that a system reset arrived while a shutdown was being signalled. A system reset leaves the flag in place. Only a power-on reset or a software write of 1 clears it. A 6-bit divider produces the sample tick from the block clock. Software reaches all settings through a small word-addressed register map.

Top module: `thermal_guard`

## Requirements
- R1: After power-on reset, the auto-control register (0x04) reads 0, the normal-period register (0x68) reads 0, and no conversion is requested. irq and shut_req are 0 and shut_pin is 1, because the pin is active-low by default.
- R2: Register 0x00 bits [5:0] hold D, and the sample tick repeats every D+1 clocks. While no channel is hot, successive conversion requests are (normal period at 0x68) × (D+1) clocks apart.
- R3: Register 0x04 bit 0 enables scanning, and bits 4..7 enable channels 0..3. Enabled channels are converted in ascending index order and wrap back to the lowest. Each response ends its request.
- R4: A returned code is stored and can be read at 0x20 + 4·channel.
- R5: The interrupt threshold is at 0x30 + 4·ch and the interrupt debounce count N is at 0x60. A code at or below the threshold counts as beyond it. The pending bit for a channel (0x0C, bit = channel) sets only after N consecutive samples of that channel are beyond the threshold. A sample that is not beyond the threshold restarts the count.
- R6: Pending bits are cleared by writing 1 to them. irq is the OR of the pending bits masked by register 0x08 bits 0..3.
- R7: While any enabled channel's latest sample is beyond its interrupt threshold, the request spacing uses the hot period (0x6C) instead of the normal period. Once no channel is beyond its threshold, the spacing returns to the normal period.
- R8: The shutdown threshold is at 0x40 + 4·ch and the shutdown debounce count is at 0x64. A channel's shutdown state latches after that many consecutive samples at or below the threshold. It stays latched until reset.
- R9: Register 0x08 bits 4..7 route the latched shutdown of channels 0..3 to shut_pin, and bits 8..11 route it to shut_req. Register 0x04 bit 8 = 1 makes shut_pin active-high.
- R10: A system reset taken while shut_pin or shut_req is active sets register 0x04 bit 24. The flag survives system resets and is cleared by writing 1 to bit 24 or by power-on reset. A system reset with no active shutdown leaves it at 0.
- R11: With bit 0 of register 0x04 at 0, no conversion is requested, even when channel enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the sticky flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| conv_req | output | 1 | Conversion request, held until conv_valid |
| conv_chan | output | 2 | Channel to convert |
| conv_valid | input | 1 | Converter result valid |
| conv_code | input | 12 | Converter result code |
| irq | output | 1 | Interrupt |
| shut_pin | output | 1 | Shutdown pin, polarity per register 0x04 bit 8 |
| shut_req | output | 1 | Shutdown request to the clock/reset unit |

## Verification
The code source steps one channel through a vector table that probes the debounce. The patterns are:
- a code exactly equal to the threshold;
- one hot sample broken by a cool one;
- two consecutive hot samples.

Together they separate a `<` compare from a `<=` compare and a restarting counter from an accumulating one.

Measuring the request spacing shows three further things:
- it follows the divider setting;
- it switches between the normal and hot periods;
- a hot second channel alone is enough to switch it.

Shutdown is driven separately on each channel to show:
- latching after the hot code goes away;
- the polarity flip;
- routing to the pin and not to the request, and the reverse;
- the sticky flag across system resets with and without an active shutdown.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_AUTO = 8'h04;
    localparam logic [7:0] A_IEN  = 8'h08;
    localparam logic [7:0] A_PEND = 8'h0C;
    localparam logic [7:0] A_DATA = 8'h20;
    localparam logic [7:0] A_ITHR = 8'h30;
    localparam logic [7:0] A_STHR = 8'h40;
    localparam logic [7:0] A_IDEB = 8'h60;
    localparam logic [7:0] A_SDEB = 8'h64;
    localparam logic [7:0] A_PNOR = 8'h68;
    localparam logic [7:0] A_PHOT = 8'h6C;

    localparam int SRC_LSB  = 4;
    localparam int POL_BIT  = 8;
    localparam int FLAG_BIT = 24;

    typedef enum logic {SCAN_WAIT, SCAN_REQ} scan_e;
endpackage

// File: rtl/tg_tick_div.sv
module tg_tick_div #(
    parameter int DIVW = 6
) (
    input  logic            clk,
    input  logic            clr,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == div);

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    // R2: a tick is never followed directly by another unless divide-by-one
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (clr)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/tg_debounce.sv
module tg_debounce #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          upd,
    input  logic          hit,
    input  logic [DW-1:0] limit,
    output logic          fire
);
    logic [DW-1:0] cnt_d, cnt_q, lim;
    logic          reach;

    assign lim   = (limit == '0) ? {{(DW-1){1'b0}}, 1'b1} : limit;
    assign reach = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim};
    assign fire  = upd && hit && reach;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (upd)  cnt_d = !hit ? '0 : (reach ? lim : cnt_q + 1'b1);
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    // R5: a sample that is not beyond the threshold restarts the count
    a_r5_miss_restarts: assert property (@(posedge clk) disable iff (clr)
        (upd && !hit) |=> (cnt_q == '0));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter  int NCH  = 4,
    parameter  int CW   = 12,
    parameter  int PW   = 16,
    parameter  int DW   = 8,
    parameter  int DIVW = 6,
    parameter  int AW   = 8,
    parameter  int BW   = 32,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [BW-1:0]  bus_wdata,
    output logic [BW-1:0]  bus_rdata,
    output logic           conv_req,
    output logic [CHW-1:0] conv_chan,
    input  logic           conv_valid,
    input  logic [CW-1:0]  conv_code,
    output logic           irq,
    output logic           shut_pin,
    output logic           shut_req
);
    typedef struct packed {
        logic [DIVW-1:0]         div;
        logic                    auto_en;
        logic [NCH-1:0]          src_en;
        logic                    pol_hi;
        logic                    flag;
        logic [3*NCH-1:0]        ien;
        logic [NCH-1:0]          pend;
        logic [NCH-1:0]          hot;
        logic [NCH-1:0]          shut;
        logic [NCH-1:0][CW-1:0]  data;
        logic [NCH-1:0][CW-1:0]  ithr;
        logic [NCH-1:0][CW-1:0]  sthr;
        logic [DW-1:0]           ideb;
        logic [DW-1:0]           sdeb;
        logic [PW-1:0]           per_n;
        logic [PW-1:0]           per_h;
        logic [PW-1:0]           wcnt;
        scan_e                   st;
        logic [CHW-1:0]          cur;
        logic [CHW-1:0]          chan;
    } state_t;

    state_t         d, q;
    logic           clr, tick, pin_act, cru_act;
    logic [PW-1:0]  per_sel, per_eff;
    logic [NCH-1:0] ihit, shit, upd, ifire, sfire;
    logic           unused_wbits;

    assign clr          = !rst_n || !por_n;
    assign unused_wbits = ^bus_wdata;

    function automatic logic [CHW-1:0] pick(input logic [CHW-1:0] start,
                                            input logic [NCH-1:0] en);
        logic [CHW-1:0] idx;
        pick = start;
        for (int k = NCH - 1; k >= 0; k--) begin
            idx = CHW'((int'(start) + k) % NCH);
            if (en[idx]) pick = idx;
        end
    endfunction

    tg_tick_div #(.DIVW(DIVW)) u_div (
        .clk(clk), .clr(clr), .div(q.div), .tick(tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign ihit[i] = conv_code <= q.ithr[i];
        assign shit[i] = conv_code <= q.sthr[i];
        assign upd[i]  = (q.st == SCAN_REQ) && conv_valid && (q.chan == CHW'(i));
        tg_debounce #(.DW(DW)) u_ideb (
            .clk(clk), .clr(clr), .upd(upd[i]), .hit(ihit[i]),
            .limit(q.ideb), .fire(ifire[i])
        );
        tg_debounce #(.DW(DW)) u_sdeb (
            .clk(clk), .clr(clr), .upd(upd[i]), .hit(shit[i]),
            .limit(q.sdeb), .fire(sfire[i])
        );
    end

    assign per_sel = |(q.hot & q.src_en) ? q.per_h : q.per_n;
    assign per_eff = (per_sel == '0) ? {{(PW-1){1'b0}}, 1'b1} : per_sel;
    assign pin_act = |(q.shut & q.ien[2*NCH-1:NCH]);
    assign cru_act = |(q.shut & q.ien[3*NCH-1:2*NCH]);

    assign conv_req  = (q.st == SCAN_REQ);
    assign conv_chan = q.chan;
    assign irq       = |(q.pend & q.ien[NCH-1:0]);
    assign shut_pin  = q.pol_hi ? pin_act : !pin_act;
    assign shut_req  = cru_act;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_CTRL)) bus_rdata[DIVW-1:0] = q.div;
        if (bus_addr == AW'(A_AUTO)) begin
            bus_rdata[0]                  = q.auto_en;
            bus_rdata[SRC_LSB +: NCH]     = q.src_en;
            bus_rdata[POL_BIT]            = q.pol_hi;
            bus_rdata[FLAG_BIT]           = q.flag;
        end
        if (bus_addr == AW'(A_IEN))  bus_rdata[3*NCH-1:0] = q.ien;
        if (bus_addr == AW'(A_PEND)) bus_rdata[NCH-1:0]   = q.pend;
        if (bus_addr == AW'(A_IDEB)) bus_rdata[DW-1:0]    = q.ideb;
        if (bus_addr == AW'(A_SDEB)) bus_rdata[DW-1:0]    = q.sdeb;
        if (bus_addr == AW'(A_PNOR)) bus_rdata[PW-1:0]    = q.per_n;
        if (bus_addr == AW'(A_PHOT)) bus_rdata[PW-1:0]    = q.per_h;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(A_DATA) + AW'(4*i)) bus_rdata[CW-1:0] = q.data[i];
            if (bus_addr == AW'(A_ITHR) + AW'(4*i)) bus_rdata[CW-1:0] = q.ithr[i];
            if (bus_addr == AW'(A_STHR) + AW'(4*i)) bus_rdata[CW-1:0] = q.sthr[i];
        end
    end

    always_comb begin
        d = q;
        if (bus_we) begin
            if (bus_addr == AW'(A_CTRL)) d.div = bus_wdata[DIVW-1:0];
            if (bus_addr == AW'(A_AUTO)) begin
                d.auto_en = bus_wdata[0];
                d.src_en  = bus_wdata[SRC_LSB +: NCH];
                d.pol_hi  = bus_wdata[POL_BIT];
                if (bus_wdata[FLAG_BIT]) d.flag = 1'b0;
            end
            if (bus_addr == AW'(A_IEN))  d.ien   = bus_wdata[3*NCH-1:0];
            if (bus_addr == AW'(A_PEND)) d.pend  = q.pend & ~bus_wdata[NCH-1:0];
            if (bus_addr == AW'(A_IDEB)) d.ideb  = bus_wdata[DW-1:0];
            if (bus_addr == AW'(A_SDEB)) d.sdeb  = bus_wdata[DW-1:0];
            if (bus_addr == AW'(A_PNOR)) d.per_n = bus_wdata[PW-1:0];
            if (bus_addr == AW'(A_PHOT)) d.per_h = bus_wdata[PW-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(A_ITHR) + AW'(4*i)) d.ithr[i] = bus_wdata[CW-1:0];
                if (bus_addr == AW'(A_STHR) + AW'(4*i)) d.sthr[i] = bus_wdata[CW-1:0];
            end
        end

        case (q.st)
            SCAN_WAIT: begin
                if (q.auto_en && (|q.src_en) && tick) begin
                    if (({1'b0, q.wcnt} + 1'b1) >= {1'b0, per_eff}) begin
                        d.wcnt = '0;
                        d.chan = pick(q.cur, q.src_en);
                        d.st   = SCAN_REQ;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            SCAN_REQ: begin
                if (conv_valid) begin
                    d.data[q.chan] = conv_code;
                    d.hot[q.chan]  = ihit[q.chan];
                    d.cur          = pick(q.chan + 1'b1, {NCH{1'b1}});
                    d.st           = SCAN_WAIT;
                end
            end
            default: d.st = SCAN_WAIT;
        endcase

        d.pend = d.pend | ifire;
        d.shut = q.shut | sfire;

        if (!d.auto_en) begin
            d.st   = SCAN_WAIT;
            d.wcnt = '0;
        end

        if (!por_n) begin
            d = '0;
        end else if (!rst_n) begin
            d      = '0;
            d.flag = q.flag || pin_act || cru_act;
        end
    end

    always_ff @(posedge clk) q <= d;

    // R8: a latched shutdown never falls without reset
    a_r8_shut_holds: assert property (@(posedge clk) disable iff (clr)
        (|q.shut) |=> (|q.shut));

    // R11: no request while automatic mode is off
    a_r11_req_needs_auto: assert property (@(posedge clk) disable iff (clr)
        conv_req |-> q.auto_en);

    // R3: one response ends the request
    a_r3_one_sample_per_req: assert property (@(posedge clk) disable iff (clr)
        (conv_req && conv_valid) |=> !conv_req);

    // R5: a pending bit only appears right after a converter response
    a_r5_pend_after_sample: assert property (@(posedge clk) disable iff (clr)
        $rose(|q.pend) |-> $past(conv_valid));
endmodule

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n, rst_n, bus_we, conv_valid;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, rv;
    logic        conv_req, irq, shut_pin, shut_req;
    logic [1:0]  conv_chan;
    logic [11:0] conv_code;
    logic [11:0] codes [4];

    int nchk = 0, nerr = 0, cyc = 0, last_cyc = 0, gap = 0, nconv = 0;
    int hist [16];
    bit done = 0;

    // columns: ch1 code, ch2 code, expected pending (0x0C), expected request gap
    localparam int NV = 5;
    localparam int VT [NV][4] = '{
        '{3000, 3000, 0, 40},
        '{2000, 3000, 0, 20},
        '{3000, 3000, 0, 40},
        '{1999, 3000, 0, 20},
        '{1999, 3000, 2, 20}
    };

    thermal_guard uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_valid(conv_valid), .conv_code(conv_code),
        .irq(irq), .shut_pin(shut_pin), .shut_req(shut_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // converter model: answers every request one half-cycle later
    initial begin
        conv_valid = 1'b0;
        conv_code  = '0;
        forever begin
            @(negedge clk);
            if (conv_req && !conv_valid) begin
                conv_valid = 1'b1;
                conv_code  = codes[conv_chan];
                gap        = cyc - last_cyc;
                last_cyc   = cyc;
                if (nconv < 16) hist[nconv] = int'(conv_chan);
                nconv++;
            end else begin
                conv_valid = 1'b0;
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_convs(input int n);
        int target = nconv + n;
        while (nconv < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        por_n = 1'b0; rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < 4; i++) codes[i] = 12'd3000;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h04, rv); chk("R1 auto reg", rv, 0);
        rd(8'h68, rv); chk("R1 normal period", rv, 0);
        chk("R1 shut_pin idle high", shut_pin, 1);
        chk("R1 irq", irq, 0);
        chk("R1 shut_req", shut_req, 0);
        chk("R1 conv_req", conv_req, 0);

        wr(8'h00, 3);
        wr(8'h34, 2000); wr(8'h38, 2000);
        wr(8'h44, 1000); wr(8'h48, 1000);
        wr(8'h60, 2);    wr(8'h64, 2);
        wr(8'h68, 10);   wr(8'h6C, 5);
        wr(8'h08, 32'h42F);
        wr(8'h04, 32'h61);

        // R5 debounce and R2/R7 spacing from the vector table
        for (int r = 0; r < NV; r++) begin
            codes[1] = 12'(VT[r][0]);
            codes[2] = 12'(VT[r][1]);
            wait_convs(2);
            rd(8'h0C, rv); chk($sformatf("R5 pending row %0d", r), rv, VT[r][2]);
            chk($sformatf("R7 gap row %0d (R2 base spacing)", r), gap, VT[r][3]);
        end
        // R3: ascending order with wrap
        chk("R3 order 0", hist[0], 1); chk("R3 order 1", hist[1], 2);
        chk("R3 order 2", hist[2], 1); chk("R3 order 3", hist[3], 2);

        // R6: irq and write-1-to-clear
        chk("R6 irq set", irq, 1);
        codes[1] = 12'd3000;
        wait_convs(2);
        wr(8'h0C, 32'h2);
        rd(8'h0C, rv); chk("R6 pending cleared", rv, 0);
        chk("R6 irq cleared", irq, 0);
        wait_convs(2);
        rd(8'h0C, rv); chk("R6 stays clear", rv, 0);

        // R4: data capture
        codes[2] = 12'd2500;
        wait_convs(2);
        rd(8'h28, rv); chk("R4 data ch2", rv, 2500);
        rd(8'h24, rv); chk("R4 data ch1", rv, 3000);

        // R7: second channel alone selects hot period, then back
        codes[2] = 12'd1500;
        wait_convs(4); chk("R7 hot gap via ch2", gap, 20);
        codes[2] = 12'd3000;
        wait_convs(4); chk("R7 back to normal", gap, 40);

        // R2: divider change
        wr(8'h00, 1);
        wait_convs(4); chk("R2 spacing div 2", gap, 20);

        // R8: shutdown debounce, latch, polarity
        codes[1] = 12'd900;
        wait_convs(2); chk("R8 one sample no trip", shut_pin, 1);
        wait_convs(2); chk("R8 trip active low", shut_pin, 0);
        chk("R9 ch1 not on request", shut_req, 0);
        codes[1] = 12'd3000;
        wait_convs(2); chk("R8 latched", shut_pin, 0);
        wr(8'h04, 32'h161);
        chk("R9 active high", shut_pin, 1);
        codes[2] = 12'd900;
        wait_convs(4); chk("R9 ch2 on request", shut_req, 1);

        // R10: sticky flag
        sys_reset();
        rd(8'h04, rv); chk("R10 flag set", rv, 32'h0100_0000);
        chk("R10 pin cleared", shut_pin, 1);
        chk("R10 request cleared", shut_req, 0);
        wr(8'h04, 32'h0100_0000);
        rd(8'h04, rv); chk("R10 flag write-1 clear", rv, 0);
        sys_reset();
        rd(8'h04, rv); chk("R10 no shutdown no flag", rv, 0);

        // R11: sources enabled, auto off
        begin
            int n0;
            wr(8'h04, 32'h60);
            n0 = nconv;
            repeat (300) @(negedge clk);
            chk("R11 no conversions", nconv, n0);
            chk("R11 conv_req low", conv_req, 0);
        end

        report();
    end
endmodule